// File: doc/BRIEF.md
# Per-Link Test Pattern Injector

This block sits in the data path of one front-end link. In normal running it forwards the live channel sample to its output, registered once. A host can fill a private pattern memory of 128 ten-bit words and write a control register that holds an arming flag and the index of the last pattern word. Arming alone changes nothing on the output. Injection starts only when the broadcast test trigger arrives while the block is armed. The block then plays the stored words from index 0 up to the programmed last index, once. After that it returns to live data.

The memory keeps its contents after a run. Because the arming flag does not clear itself, the next trigger replays the same pattern without a reload. A free-running 12-bit bunch-crossing counter is cleared by the orbit marker. The block latches the counter value at each trigger that starts a run, so the time of the last injection can be read out. A busy flag shows that playback is in progress. Each link has its own instance, so each channel can carry its own pattern.

Top module: `pattern_injector`

## Requirements
- R1: While reset is asserted and after its release, `data_o`, `busy_o` and `trig_bx_o` are 0. The arming flag is clear and the last index is 0.
- R2: When no playback is in progress, `data_o` equals the `live_data_i` value sampled at the previous rising edge. This holds even while the block is armed.
- R3: A `test_enable_i` pulse has no effect on `data_o`, `busy_o` or `trig_bx_o` while the arming flag is clear. The arming flag is bit 7 of a control write. A control write is `host_wr_i`=1 with `host_sel_i`=1.
- R4: A `test_enable_i` pulse that arrives at edge T while armed and idle starts a run. After edge T+1+k, `data_o` holds pattern word k, and `busy_o` is 1 from edge T on.
- R5: A run plays exactly last+1 words, where last is bits 6:0 of a control write. `busy_o` falls at edge T+last+1, and from edge T+last+2 on `data_o` follows live data again.
- R6: The last index used by a run is the one held at its start trigger. A control write during a run changes only later runs.
- R7: A pattern write (`host_wr_i`=1, `host_sel_i`=0, word `host_wdata_i` at index `host_addr_i`) takes effect when idle. It is ignored while `busy_o` is 1.
- R8: A `test_enable_i` pulse while `busy_o` is 1 neither restarts nor extends the run, and does not change `trig_bx_o`.
- R9: Pattern contents survive a run. A second trigger with no reload reproduces the same word sequence.
- R10: The bunch-crossing counter is 0 after reset. It advances by 1 per clock, wraps from 4095 to 0, and is 0 after an edge where `orbit_i` was high. `trig_bx_o` takes the counter value present at each edge where a run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | 0: pattern memory, 1: control register |
| host_addr_i | input | 7 | Pattern word index |
| host_wdata_i | input | 10 | Pattern word, or {pad, arm, last[6:0]} for control |
| live_data_i | input | 10 | Live front-end sample |
| test_enable_i | input | 1 | Broadcast test trigger pulse |
| orbit_i | input | 1 | Orbit marker, clears the bunch-crossing counter |
| data_o | output | 10 | Selected sample stream |
| busy_o | output | 1 | Playback in progress |
| trig_bx_o | output | 12 | Bunch-crossing number of the last accepted trigger |

## Verification
The hardest situation to reach from the ports is a host action that lands inside a running playback. Examples are a pattern write, a new last index or a second trigger, each of which must leave the run it hits unchanged. The stimulus times these actions to specific cycles of a known run. A random phase then mixes short and long runs with writes and triggers at random offsets. The counter wrap requires more than 4096 cycles without an orbit marker, followed by a trigger, so one long directed stretch is run before an orbit is issued.

// File: rtl/pi_pkg.sv
// Package: shared widths and types of the test pattern injector.
// Assumes the data word is wider than the pattern index, so a control
// write can carry the arming flag just above the last-index field.
package pi_pkg;
    localparam int PI_DATA_W = 10;
    localparam int PI_ADDR_W = 7;
    localparam int PI_BX_W   = 12;

    // Playback sequencer state.
    typedef enum logic {
        PLAY_IDLE = 1'b0,
        PLAY_RUN  = 1'b1
    } play_state_e;
endpackage

// File: rtl/pi_pattern_ram.sv
// Module: pattern memory of one link.
// One write port and one combinational read port. There is no reset on the
// contents, because the stored pattern must survive playback and is loaded
// by the host before use. Read and write never target the same cycle while
// playing, because the top blocks writes during a run.
module pi_pattern_ram #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a host word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the word at the playback pointer.
    always_comb begin
        rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/pi_play_ctrl.sv
// Module: single-shot playback sequencer.
// Takes a qualified start request (trigger while armed). It accepts the
// request only when idle, latches the last index, then steps a pointer from
// 0 to that index once before returning to idle. Requests during a run are
// dropped. Assumes start_req is a one-cycle pulse or a level. Either works,
// because a new start is taken only from idle.
module pi_play_ctrl
    import pi_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] last_cfg,
    output logic              busy,
    output logic              started,
    output logic [ADDR_W-1:0] ptr
);
    play_state_e       state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] last_q;
    logic              at_last;

    // Accept a start only from idle.
    always_comb begin
        started = start_req && (state_q == PLAY_IDLE);
        at_last = (ptr_q == last_q);
    end

    // Advance the state, the pointer and the latched last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PLAY_IDLE;
            ptr_q   <= '0;
            last_q  <= '0;
        end else begin
            case (state_q)
                PLAY_IDLE: begin
                    if (started) begin
                        state_q <= PLAY_RUN;
                        ptr_q   <= '0;
                        last_q  <= last_cfg;
                    end
                end
                PLAY_RUN: begin
                    if (at_last) begin
                        state_q <= PLAY_IDLE;
                        ptr_q   <= '0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: state_q <= PLAY_IDLE;
            endcase
        end
    end

    // Export the sequencer view.
    always_comb begin
        busy = (state_q == PLAY_RUN);
        ptr  = ptr_q;
    end
endmodule

// File: rtl/pi_bx_stamp.sv
// Module: bunch-crossing counter and trigger timestamp.
// Counts one per clock, wraps at the counter width and clears after an
// orbit marker. On a capture pulse it stores the count that is present at
// that edge. Assumes capture only for accepted triggers.
module pi_bx_stamp #(
    parameter int BX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            orbit_i,
    input  logic            capture_i,
    output logic [BX_W-1:0] stamp_o
);
    logic [BX_W-1:0] cnt_q;
    logic [BX_W-1:0] stamp_q;

    // Run the crossing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (orbit_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold the count of the last accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
        end else if (capture_i) begin
            stamp_q <= cnt_q;
        end
    end

    assign stamp_o = stamp_q;
endmodule

// File: rtl/pattern_injector.sv
// Module: per-link test pattern injector (top).
// Decodes host writes into the pattern memory or the control register
// (arming flag and last index). Qualifies the broadcast trigger with the
// arming flag and selects stored or live samples into a registered output.
// Assumes test_enable_i and orbit_i are already synchronous to clk and
// decoded.
module pattern_injector
    import pi_pkg::*;
#(
    parameter int DATA_W = PI_DATA_W,
    parameter int ADDR_W = PI_ADDR_W,
    parameter int BX_W   = PI_BX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic              host_sel_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic [DATA_W-1:0] live_data_i,
    input  logic              test_enable_i,
    input  logic              orbit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o,
    output logic [BX_W-1:0]   trig_bx_o
);
    localparam int ARM_BIT = ADDR_W;

    logic              arm_q;
    logic [ADDR_W-1:0] last_q;
    logic              busy;
    logic              start_ok;
    logic              start_req;
    logic              ram_we;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] pat_word;
    logic [DATA_W-1:0] data_q;

    // Hold the control register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            last_q <= '0;
        end else if (host_wr_i && host_sel_i) begin
            arm_q  <= host_wdata_i[ARM_BIT];
            last_q <= host_wdata_i[ADDR_W-1:0];
        end
    end

    // Gate the memory write and the trigger.
    always_comb begin
        ram_we    = host_wr_i && !host_sel_i && !busy;
        start_req = test_enable_i && arm_q;
    end

    pi_pattern_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (host_addr_i),
        .wr_data (host_wdata_i),
        .rd_addr (ptr),
        .rd_data (pat_word)
    );

    pi_play_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .last_cfg  (last_q),
        .busy      (busy),
        .started   (start_ok),
        .ptr       (ptr)
    );

    pi_bx_stamp #(
        .BX_W (BX_W)
    ) u_bx (
        .clk       (clk),
        .rst_n     (rst_n),
        .orbit_i   (orbit_i),
        .capture_i (start_ok),
        .stamp_o   (trig_bx_o)
    );

    // Register the selected sample stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (busy) begin
            data_q <= pat_word;
        end else begin
            data_q <= live_data_i;
        end
    end

    assign data_o = data_q;
    assign busy_o = busy;
endmodule

// File: rtl/pi_checker.sv
// Checker modules for the injector, bound to the top and to the counter.
// A warm-up count keeps every $past look inside the cycles since reset.
module pi_checker #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 7,
    parameter int BX_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic [DATA_W-1:0] data_o,
    input logic [DATA_W-1:0] live_data_i,
    input logic [BX_W-1:0]   trig_bx_o,
    input logic              test_enable_i,
    input logic              arm_q,
    input logic              start_ok,
    input logic [ADDR_W-1:0] last_q
);
    logic [1:0]      seen;
    logic            ok;
    logic [ADDR_W:0] run_len;
    logic [ADDR_W:0] exp_len;

    // Count edges since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 1'b1;
        end
    end
    assign ok = (seen >= 2'd2);

    // Measure each run and record the length it should have.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            exp_len <= '0;
        end else if (start_ok) begin
            run_len <= '0;
            exp_len <= {1'b0, last_q} + 1'b1;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R2: idle output follows live data one cycle late
    assert_live_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ok && !$past(busy_o) |-> data_o == $past(live_data_i));

    // R3: a run only begins from an armed trigger
    assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ok && $rose(busy_o) |-> $past(test_enable_i) && $past(arm_q));

    // R5: a run lasts last+1 cycles
    assert_run_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ok && $fell(busy_o) |-> run_len == exp_len);

    // R8: timestamp frozen inside a run
    assert_stamp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok && busy_o && $past(busy_o) |-> $stable(trig_bx_o));
endmodule

module pi_bx_checker #(
    parameter int BX_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            orbit_i,
    input logic [BX_W-1:0] cnt_q
);
    logic [1:0] seen;
    logic       ok;

    // Count edges since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 1'b1;
        end
    end
    assign ok = (seen >= 2'd2);

    // R10: orbit marker clears the counter
    assert_bx_orbit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ok && $past(orbit_i) |-> cnt_q == '0);

    // R10: counter steps by one with wrap
    assert_bx_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ok && !$past(orbit_i) |-> cnt_q == BX_W'($past(cnt_q) + 1'b1));
endmodule

bind pattern_injector pi_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BX_W   (BX_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .data_o        (data_o),
    .live_data_i   (live_data_i),
    .trig_bx_o     (trig_bx_o),
    .test_enable_i (test_enable_i),
    .arm_q         (arm_q),
    .start_ok      (start_ok),
    .last_q        (last_q)
);

bind pi_bx_stamp pi_bx_checker #(
    .BX_W (BX_W)
) bxchk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .orbit_i (orbit_i),
    .cnt_q   (cnt_q)
);

// File: tb/pattern_injector_tb.sv
// Bench: cycle model of the requirements, directed corner cases, then
// random traffic with a fixed seed.
module pattern_injector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_sel = 1'b0;
    logic [6:0] host_addr = '0;
    logic [9:0] host_wdata = '0;
    logic [9:0] live = '0;
    logic       te = 1'b0;
    logic       orbit = 1'b0;
    logic [9:0] data_o;
    logic       busy_o;
    logic [11:0] trig_bx_o;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    string tag = "R1";

    // model state
    int m_mem [128];
    int m_arm = 0, m_last = 0, m_busy = 0, m_ptr = 0, m_lat = 0;
    int m_bx = 0, m_trig = 0, m_out = 0;
    int seq [128];

    always #5 clk = ~clk;

    pattern_injector dut_i (
        .clk (clk), .rst_n (rst_n),
        .host_wr_i (host_wr), .host_sel_i (host_sel),
        .host_addr_i (host_addr), .host_wdata_i (host_wdata),
        .live_data_i (live), .test_enable_i (te), .orbit_i (orbit),
        .data_o (data_o), .busy_o (busy_o), .trig_bx_o (trig_bx_o)
    );

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ctrl_word(int arm, int last);
        return (arm << 7) | (last & 127);
    endfunction

    // Apply one clock edge to the model, from the pre-edge state.
    task automatic model_edge();
        int started, old_last, old_bx;
        started  = (te && m_arm && !m_busy) ? 1 : 0;
        old_last = m_last;
        old_bx   = m_bx;
        m_out = m_busy ? m_mem[m_ptr] : int'(live);
        if (host_wr && !host_sel && !m_busy) m_mem[host_addr] = int'(host_wdata);
        if (host_wr && host_sel) begin
            m_arm  = (host_wdata >> 7) & 1;
            m_last = host_wdata & 127;
        end
        if (started) begin
            m_busy = 1; m_ptr = 0; m_lat = old_last; m_trig = old_bx;
        end else if (m_busy) begin
            if (m_ptr == m_lat) begin m_busy = 0; m_ptr = 0; end
            else m_ptr = m_ptr + 1;
        end
        m_bx = orbit ? 0 : (m_bx + 1) % 4096;
    endtask

    // One cycle: edge, model, compare, then clear strobes at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        chk("data_o", int'(data_o), m_out);
        chk("busy_o", int'(busy_o), m_busy);
        chk("trig_bx_o", int'(trig_bx_o), m_trig);
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0; te = 1'b0; orbit = 1'b0;
        live = 10'($urandom);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_ram(int a, int d);
        host_wr = 1'b1; host_sel = 1'b0; host_addr = 7'(a); host_wdata = 10'(d);
        cyc();
    endtask

    task automatic wr_ctrl(int arm, int last);
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = 10'(ctrl_word(arm, last));
        cyc();
    endtask

    task automatic fire();
        te = 1'b1;
        cyc();
    endtask

    // Record the output words of a run of known length, check them against
    // the stored words, and return to idle.
    task automatic capture_run(int last, string label);
        fire();
        cyc();
        for (int k = 0; k <= last; k++) begin
            seq[k] = int'(data_o);
            chk({label, " word"}, int'(data_o), m_mem[k]);
            if (k < last) cyc();
        end
        cyc();
        chk({label, " busy after run"}, int'(busy_o), 0);
        cyc();
        chk({label, " live after run"}, int'(data_o), m_out);
    endtask

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        // R1 reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        #1;
        chk("reset data_o", int'(data_o), 0);
        chk("reset busy_o", int'(busy_o), 0);
        chk("reset trig_bx_o", int'(trig_bx_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2 live pass-through, not armed and then armed
        tag = "R2";
        idle(20);
        wr_ctrl(1, 5);
        idle(20);

        // R3 trigger while disarmed is ignored
        tag = "R3";
        wr_ctrl(0, 5);
        fire();
        idle(10);

        // load full pattern memory
        tag = "R7";
        for (int a = 0; a < 128; a++) wr_ram(a, int'(10'($urandom)));

        // R4/R5 basic run of 10 words
        tag = "R4 R5";
        wr_ctrl(1, 9);
        capture_run(9, "R4");
        tag = "R10";
        chk("stamp after first run", int'(trig_bx_o), m_trig);

        // R9 replay without reload
        tag = "R9";
        begin
            int first [10];
            for (int k = 0; k < 10; k++) first[k] = seq[k];
            idle(3);
            capture_run(9, "R9");
            for (int k = 0; k < 10; k++) chk("replay equals first run", seq[k], first[k]);
        end

        // R7, R8, R6 actions inside a run of 20 words
        tag = "R6 R7 R8";
        wr_ctrl(1, 19);
        fire();
        cyc();
        wr_ram(3, int'(m_mem[3]) ^ 10'h3ff);   // R7 ignored while busy
        wr_ctrl(1, 2);                          // R6 applies to later runs
        fire();                                 // R8 ignored while busy
        idle(25);
        tag = "R7";
        capture_run(2, "R7 word kept");
        tag = "R6";
        idle(2);
        capture_run(2, "R6 short run");

        // boundaries: single word and full memory
        tag = "R5";
        wr_ctrl(1, 0);
        capture_run(0, "R5 single");
        wr_ctrl(1, 127);
        capture_run(127, "R5 full");

        // R10 wrap and orbit clear
        tag = "R10";
        idle(4200);
        fire();
        idle(200);
        orbit = 1'b1;
        cyc();
        idle(6);
        fire();
        idle(200);
        chk("stamp after orbit", int'(trig_bx_o), 6);

        // random traffic
        tag = "R2 R4 R7 R8 R10";
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 10) begin
                host_wr = 1'b1;
                host_sel = ($urandom % 4) == 0;
                host_addr = 7'($urandom);
                host_wdata = host_sel ? 10'(ctrl_word(($urandom % 4) != 0, int'($urandom % 40)))
                                      : 10'($urandom);
            end
            if (($urandom % 25) == 0) te = 1'b1;
            if (($urandom % 300) == 0) orbit = 1'b1;
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule